// File: doc/BRIEF.md
# Sorted Limit Order Book Engine

This block holds the resting orders of a single instrument in two small on-chip lists, one for buyers and one for sellers. Each list is kept in price order so that slot 0 always holds the best price. Commands arrive one at a time over a valid/ready handshake. They can add an order, execute against it (partly or fully), reduce it, modify it, delete it, read the best order of a side, or read out a whole side. Every command produces at least one result on a result port that pulses valid for one cycle per result.

Adds walk the list from the best slot and place the new order at the first slot where its price belongs, pushing every later order one slot back. Removals use a read cursor and a write cursor, so the list is compacted in a single pass. In-place updates stop as soon as the matching order is rewritten. A modify removes the order and inserts it again at its new price, so the list stays sorted. A full side dump streams one order per cycle, best first.

Top module: `order_book`

## Requirements
- R1: A command is taken only on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance until the command's last result has been issued. A command presented while `cmd_ready` is low is ignored and changes nothing.
- R2: An add (op 0) places the order so that the buy side is in descending price order and the sell side in ascending price order. An order whose price equals that of resting orders goes behind all of them. It returns one found result carrying the new order.
- R3: An add to a side that already holds DEPTH orders is dropped and returns one not-found result. The book is left unchanged.
- R4: A delete (op 4) removes the order with the matching id from the named side and closes the gap. It returns one found result carrying the removed order.
- R5: An execute (op 1) whose `cmd_exec_qty` is below the resting quantity lowers that quantity in place and returns the remaining order. Otherwise it removes the order as a delete does and returns the order as it was before removal.
- R6: A reduce (op 2) replaces the matching order's quantity with `cmd_qty`, keeps its position, and returns the updated order.
- R7: A modify (op 3) replaces the matching order's quantity with `cmd_qty` and its price with `cmd_price`. It keeps the id and symbol and re-sorts the order as a new arrival, behind equal prices. It returns the updated order.
- R8: An execute, reduce, modify or delete whose id is not resting on the named side returns one not-found result. That result has `res_found`=0, echoes the command id and side, and has zero quantity, price and symbol.
- R9: A get-top (op 5) returns exactly one result: the best order of the named side. If the side is empty it returns a not-found result.
- R10: A get-all (op 6) returns every order of the named side in sorted order. The results come on consecutive cycles, with `res_valid` high for one cycle per order. An empty side returns one not-found result.
- R11: `cmd_side` equal to 0x53 ('S') selects the sell side and any other value selects the buy side. `res_side` is 0x42 ('B') or 0x53 ('S'). Op codes 0 to 6 are as listed above. Code 7 returns one not-found result and changes nothing.
- R12: While `rst_n` is low both sides are emptied, `res_valid` is low, and after release `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Command code |
| cmd_side | input | 8 | Side as ASCII letter |
| cmd_id | input | 64 | Order id |
| cmd_qty | input | 32 | Quantity for add, reduce, modify |
| cmd_exec_qty | input | 32 | Executed quantity for execute |
| cmd_price | input | 32 | Fixed-point price for add, modify |
| cmd_symbol | input | 32 | Symbol for add |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | 1 = order found or placed |
| res_side | output | 8 | Side as ASCII letter |
| res_id | output | 64 | Order id |
| res_qty | output | 32 | Quantity |
| res_price | output | 32 | Price |
| res_symbol | output | 32 | Symbol |

## Verification
The bench adds orders at equal prices on both sides. An engine that compared with "greater or equal" would put a newcomer ahead of the older order and break time priority in the dump. It deletes and fully executes orders in the middle of the list. A broken compaction cursor would duplicate or lose the order behind the gap. It fills the sell side to capacity and adds one more, then presents a command while the block is busy. A miscounted limit or a leaky handshake would show as a corrupted list, and a slow or restarted stream would show as results missing from consecutive cycles.

// File: rtl/order_book.sv
module order_book #(
  parameter int DEPTH = 16,
  parameter int IDW   = 64,
  parameter int QW    = 32,
  parameter int PW    = 32,
  parameter int SW    = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [7:0]     cmd_side,
  input  logic [IDW-1:0] cmd_id,
  input  logic [QW-1:0]  cmd_qty,
  input  logic [QW-1:0]  cmd_exec_qty,
  input  logic [PW-1:0]  cmd_price,
  input  logic [SW-1:0]  cmd_symbol,
  output logic           res_valid,
  output logic           res_found,
  output logic [7:0]     res_side,
  output logic [IDW-1:0] res_id,
  output logic [QW-1:0]  res_qty,
  output logic [PW-1:0]  res_price,
  output logic [SW-1:0]  res_symbol
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int N  = 2 * DEPTH;
  localparam logic [2:0] OP_ADD = 3'd0, OP_EXEC = 3'd1, OP_RED = 3'd2,
                         OP_MOD = 3'd3, OP_DEL  = 3'd4, OP_TOP = 3'd5, OP_ALL = 3'd6;

  typedef struct packed {
    logic [IDW-1:0] id;
    logic [QW-1:0]  qty;
    logic [PW-1:0]  price;
    logic [SW-1:0]  sym;
  } ent_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_INS, ST_SCAN, ST_DUMP} st_t;

  ent_t          mem [N];
  logic [CW-1:0] cnt [2];
  st_t           st;
  logic [2:0]    op;
  logic          sd;
  ent_t          nw, carry, res_e, cur, wd;
  logic [QW-1:0] xq, newq;
  logic          placed, hit, res_sd, we;
  logic [CW-1:0] rd, wr, n_cur;
  logic [AW:0]   ra, wa, wadr, base;
  logic          last, at_end, better, take, m, inplace;

  assign cmd_ready  = (st == ST_IDLE);
  assign n_cur      = cnt[sd];
  assign base       = sd ? (AW+1)'(DEPTH) : '0;
  assign ra         = (AW+1)'(rd) + base;
  assign wa         = (AW+1)'(wr) + base;
  assign cur        = mem[ra];
  assign last       = (rd == n_cur - CW'(1));
  assign at_end     = (rd == n_cur);
  assign better     = sd ? (nw.price < cur.price) : (nw.price > cur.price);
  assign take       = !placed && (at_end || better);
  assign m          = !hit && (cur.id == nw.id);
  assign inplace    = (op == OP_RED) || ((op == OP_EXEC) && (xq < cur.qty));
  assign newq       = (op == OP_RED) ? nw.qty : cur.qty - xq;

  assign res_side   = res_sd ? 8'h53 : 8'h42;
  assign res_id     = res_e.id;
  assign res_qty    = res_e.qty;
  assign res_price  = res_e.price;
  assign res_symbol = res_e.sym;

  always_comb begin
    we   = 1'b0;
    wadr = ra;
    wd   = cur;
    if (st == ST_INS) begin
      if (take) begin
        we = 1'b1;
        wd = nw;
      end else if (placed) begin
        we = 1'b1;
        wd = carry;
      end
    end else if (st == ST_SCAN) begin
      if (m && inplace) begin
        we     = 1'b1;
        wd.qty = newq;
      end else if (!m && hit) begin
        we   = 1'b1;
        wadr = wa;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wadr] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      op        <= '0;
      sd        <= 1'b0;
      nw        <= '0;
      xq        <= '0;
      carry     <= '0;
      placed    <= 1'b0;
      hit       <= 1'b0;
      rd        <= '0;
      wr        <= '0;
      res_valid <= 1'b0;
      res_found <= 1'b0;
      res_sd    <= 1'b0;
      res_e     <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op       <= cmd_op;
          sd       <= (cmd_side == 8'h53);
          nw.id    <= cmd_id;
          nw.qty   <= cmd_qty;
          nw.price <= cmd_price;
          nw.sym   <= cmd_symbol;
          xq       <= cmd_exec_qty;
          rd       <= '0;
          wr       <= '0;
          hit      <= 1'b0;
          placed   <= 1'b0;
          st       <= ST_START;
        end
        ST_START: begin
          res_sd <= sd;
          st     <= ST_IDLE;
          case (op)
            OP_ADD:
              if (n_cur == CW'(DEPTH)) begin
                res_valid <= 1'b1;
                res_found <= 1'b0;
                res_e     <= '0;
                res_e.id  <= nw.id;
              end else st <= ST_INS;
            OP_EXEC, OP_RED, OP_MOD, OP_DEL, OP_TOP, OP_ALL:
              if (n_cur == '0) begin
                res_valid <= 1'b1;
                res_found <= 1'b0;
                res_e     <= '0;
                res_e.id  <= nw.id;
              end else if (op == OP_TOP) begin
                res_valid <= 1'b1;
                res_found <= 1'b1;
                res_e     <= cur;
              end else if (op == OP_ALL) st <= ST_DUMP;
              else st <= ST_SCAN;
            default: begin
              res_valid <= 1'b1;
              res_found <= 1'b0;
              res_e     <= '0;
              res_e.id  <= nw.id;
            end
          endcase
        end
        ST_INS: begin
          if (take) placed <= 1'b1;
          if (take || placed) carry <= cur;
          if (at_end) begin
            cnt[sd]   <= cnt[sd] + CW'(1);
            res_valid <= 1'b1;
            res_found <= 1'b1;
            res_e     <= nw;
            st        <= ST_IDLE;
          end else rd <= rd + CW'(1);
        end
        ST_SCAN: begin
          if (m && inplace) begin
            res_valid  <= 1'b1;
            res_found  <= 1'b1;
            res_e      <= cur;
            res_e.qty  <= newq;
            st         <= ST_IDLE;
          end else begin
            if (m) begin
              hit   <= 1'b1;
              carry <= cur;
            end else wr <= wr + CW'(1);
            rd <= rd + CW'(1);
            if (last) begin
              st <= ST_IDLE;
              if (hit || m) begin
                cnt[sd] <= cnt[sd] - CW'(1);
                if (op == OP_MOD) begin
                  nw.sym <= m ? cur.sym : carry.sym;
                  rd     <= '0;
                  placed <= 1'b0;
                  st     <= ST_INS;
                end else begin
                  res_valid <= 1'b1;
                  res_found <= 1'b1;
                  res_e     <= m ? cur : carry;
                end
              end else begin
                res_valid <= 1'b1;
                res_found <= 1'b0;
                res_e     <= '0;
                res_e.id  <= nw.id;
              end
            end
          end
        end
        ST_DUMP: begin
          res_valid <= 1'b1;
          res_found <= 1'b1;
          res_e     <= cur;
          if (last) st <= ST_IDLE;
          else rd <= rd + CW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= CW'(DEPTH)) && (cnt[1] <= CW'(DEPTH)));

  p_buy_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] != $past(cnt[0])) |->
      ((cnt[0] == $past(cnt[0]) + CW'(1)) || (cnt[0] + CW'(1) == $past(cnt[0]))));

  p_sell_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[1] != $past(cnt[1])) |->
      ((cnt[1] == $past(cnt[1]) + CW'(1)) || (cnt[1] + CW'(1) == $past(cnt[1]))));

  p_notfound_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_found) |-> (res_qty == '0 && res_price == '0 && res_symbol == '0));

  p_buy_sorted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid) && res_found && $past(res_found) &&
     res_side == 8'h42 && $past(res_side) == 8'h42) |-> (res_price <= $past(res_price)));

  p_sell_sorted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid) && res_found && $past(res_found) &&
     res_side == 8'h53 && $past(res_side) == 8'h53) |-> (res_price >= $past(res_price)));

  p_side_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_side == 8'h42 || res_side == 8'h53));
endmodule

// File: tb/order_book_bench.sv
module order_book_bench;
  localparam int DEPTH = 16;
  localparam logic [7:0] B = 8'h42, S = 8'h53;

  typedef struct packed {
    logic [63:0] id;
    logic [31:0] qty;
    logic [31:0] price;
    logic [31:0] sym;
  } ent_t;

  typedef struct packed {
    logic found;
    logic sell;
    logic cont;
    ent_t e;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_side = '0;
  logic [63:0] cmd_id = '0;
  logic [31:0] cmd_qty = '0, cmd_exec_qty = '0, cmd_price = '0, cmd_symbol = '0;
  logic cmd_ready, res_valid, res_found;
  logic [7:0] res_side;
  logic [63:0] res_id;
  logic [31:0] res_qty, res_price, res_symbol;

  int checks = 0, errors = 0, cyc = 0, last_cyc = 0;
  bit done = 1'b0;

  exp_t  expq[$];
  string tagq[$];
  ent_t  bk [2][DEPTH];
  int    n  [2];

  order_book u_order_book (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_side(cmd_side), .cmd_id(cmd_id), .cmd_qty(cmd_qty),
    .cmd_exec_qty(cmd_exec_qty), .cmd_price(cmd_price), .cmd_symbol(cmd_symbol),
    .res_valid(res_valid), .res_found(res_found), .res_side(res_side),
    .res_id(res_id), .res_qty(res_qty), .res_price(res_price), .res_symbol(res_symbol));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic push(input bit found, input bit sell, input bit cont, input ent_t e, input string tag);
    exp_t x;
    x.found = found; x.sell = sell; x.cont = cont; x.e = e;
    expq.push_back(x);
    tagq.push_back(tag);
  endtask

  task automatic push_nf(input bit sell, input logic [63:0] id, input string tag);
    ent_t e;
    e = '0; e.id = id;
    push(1'b0, sell, 1'b0, e, tag);
  endtask

  function automatic int find(input int s, input logic [63:0] id);
    for (int i = 0; i < n[s]; i++) if (bk[s][i].id == id) return i;
    return -1;
  endfunction

  task automatic m_ins(input int s, input ent_t e);
    int pos;
    pos = n[s];
    for (int i = n[s] - 1; i >= 0; i--)
      if (s == 1 ? (e.price < bk[s][i].price) : (e.price > bk[s][i].price)) pos = i;
    for (int i = n[s]; i > pos; i--) bk[s][i] = bk[s][i-1];
    bk[s][pos] = e;
    n[s]++;
  endtask

  task automatic m_rm(input int s, input int p);
    for (int i = p; i < n[s] - 1; i++) bk[s][i] = bk[s][i+1];
    n[s]--;
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] side, input logic [63:0] id,
                       input logic [31:0] qty, input logic [31:0] xq, input logic [31:0] price,
                       input logic [31:0] sym, input string tag);
    int s, i;
    ent_t e;
    s = (side == S) ? 1 : 0;
    i = find(s, id);
    e.id = id; e.qty = qty; e.price = price; e.sym = sym;
    case (op)
      3'd0: if (n[s] == DEPTH) push_nf(s[0], id, tag);
            else begin m_ins(s, e); push(1'b1, s[0], 1'b0, e, tag); end
      3'd1: if (i < 0) push_nf(s[0], id, tag);
            else if (xq < bk[s][i].qty) begin
              bk[s][i].qty = bk[s][i].qty - xq; push(1'b1, s[0], 1'b0, bk[s][i], tag);
            end else begin e = bk[s][i]; m_rm(s, i); push(1'b1, s[0], 1'b0, e, tag); end
      3'd2: if (i < 0) push_nf(s[0], id, tag);
            else begin bk[s][i].qty = qty; push(1'b1, s[0], 1'b0, bk[s][i], tag); end
      3'd3: if (i < 0) push_nf(s[0], id, tag);
            else begin
              e.sym = bk[s][i].sym; m_rm(s, i); m_ins(s, e); push(1'b1, s[0], 1'b0, e, tag);
            end
      3'd4: if (i < 0) push_nf(s[0], id, tag);
            else begin e = bk[s][i]; m_rm(s, i); push(1'b1, s[0], 1'b0, e, tag); end
      3'd5: if (n[s] == 0) push_nf(s[0], id, tag);
            else push(1'b1, s[0], 1'b0, bk[s][0], tag);
      3'd6: if (n[s] == 0) push_nf(s[0], id, tag);
            else for (int k = 0; k < n[s]; k++) push(1'b1, s[0], k > 0, bk[s][k], tag);
      default: push_nf(s[0], id, tag);
    endcase
    do @(negedge clk); while (!cmd_ready);
    cmd_op = op; cmd_side = side; cmd_id = id; cmd_qty = qty;
    cmd_exec_qty = xq; cmd_price = price; cmd_symbol = sym;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((expq.size() != 0 || !cmd_ready) && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      exp_t x;
      string tg;
      if (expq.size() == 0) begin
        chk(1'b0, "R1 unexpected result", res_id, 64'h0);
      end else begin
        x = expq.pop_front();
        tg = tagq.pop_front();
        chk(res_found == x.found, {tg, " found"}, 64'(res_found), 64'(x.found));
        chk(res_side == (x.sell ? S : B), {tg, " side"}, 64'(res_side), 64'(x.sell ? S : B));
        chk(res_id == x.e.id, {tg, " id"}, res_id, x.e.id);
        chk(res_qty == x.e.qty, {tg, " qty"}, 64'(res_qty), 64'(x.e.qty));
        chk(res_price == x.e.price, {tg, " price"}, 64'(res_price), 64'(x.e.price));
        chk(res_symbol == x.e.sym, {tg, " symbol"}, 64'(res_symbol), 64'(x.e.sym));
        if (x.cont) chk(cyc == last_cyc + 1, {tg, " consecutive"}, 64'(cyc), 64'(last_cyc + 1));
      end
      last_cyc = cyc;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    n[0] = 0; n[1] = 0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R12 res_valid in reset", 64'(res_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R12 ready after reset", 64'(cmd_ready), 64'h1);

    issue(3'd5, B, 64'h1, 0, 0, 0, 0, "R9 top of empty buy");
    issue(3'd6, S, 64'h2, 0, 0, 0, 0, "R10 dump of empty sell");

    issue(3'd0, B, 64'h1, 50, 0, 100, 32'h41424344, "R2 add buy");
    issue(3'd0, B, 64'h2, 10, 0, 105, 32'h41424344, "R2 add buy better");
    issue(3'd0, B, 64'h3, 30, 0, 100, 32'h41424344, "R2 add buy equal price");
    issue(3'd0, B, 64'h4, 40, 0,  95, 32'h41424344, "R2 add buy worse");
    issue(3'd0, S, 64'h10, 60, 0, 110, 32'h41424344, "R2 add sell");
    issue(3'd0, S, 64'h11, 70, 0, 108, 32'h41424344, "R2 add sell better");
    issue(3'd0, S, 64'h12, 80, 0, 110, 32'h41424344, "R2 add sell equal price");
    issue(3'd6, B, 64'h0, 0, 0, 0, 0, "R10 R2 dump buy");
    issue(3'd6, S, 64'h0, 0, 0, 0, 0, "R10 R2 dump sell");
    issue(3'd5, B, 64'h0, 0, 0, 0, 0, "R9 top buy");
    issue(3'd5, S, 64'h0, 0, 0, 0, 0, "R9 top sell");

    issue(3'd1, B, 64'h1, 0, 30, 0, 0, "R5 partial execute");
    issue(3'd1, S, 64'h11, 0, 500, 0, 0, "R5 full execute");
    issue(3'd6, S, 64'h0, 0, 0, 0, 0, "R5 dump sell after execute");
    issue(3'd2, B, 64'h3, 7, 0, 0, 0, "R6 reduce");
    issue(3'd4, B, 64'h2, 0, 0, 0, 0, "R4 delete head");
    issue(3'd4, B, 64'h99, 0, 0, 0, 0, "R8 delete unknown id");
    issue(3'd1, S, 64'h1, 0, 5, 0, 0, "R8 execute on wrong side");
    issue(3'd2, S, 64'h77, 9, 0, 0, 0, "R8 reduce unknown id");
    issue(3'd6, B, 64'h0, 0, 0, 0, 0, "R4 R6 dump buy");
    issue(3'd3, B, 64'h4, 9, 0, 100, 32'h0, "R7 modify to equal price");
    issue(3'd3, B, 64'h55, 9, 0, 100, 32'h0, "R8 modify unknown id");
    issue(3'd6, B, 64'h0, 0, 0, 0, 0, "R7 dump buy after modify");

    issue(3'd0, B, 64'h20, 5, 0, 50, 32'h41424344, "R1 add before busy probe");
    cmd_op = 3'd4; cmd_side = B; cmd_id = 64'h1; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b0, "R1 ready low while busy", 64'(cmd_ready), 64'h0);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 ready still low", 64'(cmd_ready), 64'h0);
    cmd_valid = 1'b0;
    issue(3'd6, B, 64'h0, 0, 0, 0, 0, "R1 dump shows ignored delete");

    issue(3'd7, B, 64'h5, 1, 1, 1, 1, "R11 unknown op");
    issue(3'd0, 8'h58, 64'h30, 3, 0, 99, 32'h41424344, "R11 other side code means buy");
    issue(3'd6, B, 64'h0, 0, 0, 0, 0, "R11 dump buy");

    for (int k = 0; k < DEPTH - 2; k++)
      issue(3'd0, S, 64'h200 + 64'(k), 32'(k + 1), 0, 32'(100 + ((k * 37) % 50)), 32'h41424344, "R2 fill sell");
    issue(3'd0, S, 64'h300, 1, 0, 101, 32'h41424344, "R3 add to full side");
    issue(3'd6, S, 64'h0, 0, 0, 0, 0, "R3 R10 dump full sell");
    drain();
    chk(expq.size() == 0, "R10 all results seen", 64'(expq.size()), 64'h0);

    rst_n = 1'b0;
    n[0] = 0; n[1] = 0;
    repeat (2) @(negedge clk);
    chk(res_valid == 1'b0, "R12 res_valid low in reset", 64'(res_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R12 ready after second reset", 64'(cmd_ready), 64'h1);
    issue(3'd6, B, 64'h0, 0, 0, 0, 0, "R12 buy empty after reset");
    issue(3'd6, S, 64'h0, 0, 0, 0, 0, "R12 sell empty after reset");
    drain();
    chk(expq.size() == 0, "R12 queue drained", 64'(expq.size()), 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule